// File: doc/BRIEF.md
# Two-Bit Saturating Branch Direction Table

This block holds one 2-bit saturating counter per table slot and turns it into a taken or not-taken guess for a branch being fetched. The slot is chosen by a few low bits of the branch address, just above the byte offset of a 32-bit instruction word. When the branch later resolves, the real outcome is written back through a separate update port. Only the direction is kept; the jump target lives elsewhere.

A counter must be wrong twice in a row before its guess changes direction. A loop branch that is taken many times and then falls through once therefore still predicts taken the next time the loop starts. The counter runs in inverted sense: small values mean taken. A taken outcome moves the counter down toward 0, and a not-taken outcome moves it up toward 3.

The read port is combinational from the table. A read and an update to the same slot in the same cycle returns the old guess, and the new value can be seen from the next cycle on.

Top module: `bp2_counter_table`

## Requirements
- R1: After reset every slot holds counter value 2, so every address reads as not taken (`rd_taken` = 0). A reset applied later restores this state.
- R2: Counter values 0 and 1 give `rd_taken` = 1. Values 2 and 3 give `rd_taken` = 0.
- R3: An update with `upd_taken` = 1 lowers the slot's counter by one, and holds it at 0 if it is already 0. A slot that read taken before such an update still reads taken after it.
- R4: An update with `upd_taken` = 0 raises the slot's counter by one, and holds it at 3 if it is already 3. A slot that read not taken before such an update still reads not taken after it.
- R5: Starting from a saturated counter, one outcome against the guess leaves the guess unchanged. A second such outcome in a row reverses it.
- R6: When `upd_valid` = 0, no slot changes, whatever `upd_addr` and `upd_taken` carry.
- R7: The slot index is address bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). Addresses that differ only in other bits share a slot. An update to one slot leaves every other slot unchanged.
- R8: A read of the slot being updated in the same cycle returns the value from before the update. The updated value can be read from the following cycle.
- R9: Take a loop branch in a fresh slot that resolves taken six times and then not taken once. Five of those seven guesses are correct, and the first guess of the loop's next run is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | ADDR_W | Address of the branch being fetched |
| rd_taken | output | 1 | Guess for `rd_addr`: 1 = taken |
| upd_valid | input | 1 | High for one cycle for each resolved branch |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome: 1 = taken |

## Verification
The counter is walked through both saturation limits and through a single miss followed by a recovery. This separates a counter that saturates from one that wraps, and a two-miss hysteresis from a one-bit history. Updates are also sent with `upd_valid` low, to other slots, and through addresses that differ only in their tag bits. These cases separate the valid gating and the index bit selection from accidental slot sharing. A loop pattern of six taken outcomes then one not taken is replayed to show the carry-over into the next run of the loop. Same-cycle read and update of one slot shows whether the read returns the old or the new value.

// File: rtl/bp2_pkg.sv
package bp2_pkg;

   // Inverted sense: low values guess taken.
   typedef enum logic [1:0] {
      CNT_STRONG_T  = 2'd0,
      CNT_WEAK_T    = 2'd1,
      CNT_WEAK_NT   = 2'd2,
      CNT_STRONG_NT = 2'd3
   } bp2_cnt_t;

   function automatic logic bp2_guess_taken(input bp2_cnt_t c);
      return (c == CNT_STRONG_T) || (c == CNT_WEAK_T);
   endfunction

   function automatic bp2_cnt_t bp2_step(input bp2_cnt_t c, input logic taken);
      bp2_cnt_t n;
      n = c;
      if (taken) begin
         if (c != CNT_STRONG_T) n = bp2_cnt_t'(c - 2'd1);
      end else begin
         if (c != CNT_STRONG_NT) n = bp2_cnt_t'(c + 2'd1);
      end
      return n;
   endfunction

endpackage

// File: rtl/bp2_index.sv
module bp2_index #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);

   assign idx = addr[IDX_W+1:2];

   // Bits outside the index field do not take part in slot selection.
   logic unused_low;
   assign unused_low = ^addr[1:0];

   generate
      if (ADDR_W > IDX_W + 2) begin : g_tag
         logic unused_tag;
         assign unused_tag = ^addr[ADDR_W-1:IDX_W+2];
      end
   endgenerate

endmodule

// File: rtl/bp2_cell.sv
module bp2_cell
   import bp2_pkg::*;
#(
   parameter bp2_cnt_t INIT = CNT_WEAK_NT
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hit,
   input  logic     outcome_taken,
   output bp2_cnt_t cnt_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= INIT;
      else if (hit) cnt_q <= bp2_step(cnt_q, outcome_taken);
   end

endmodule

// File: rtl/bp2_counter_table.sv
module bp2_counter_table
   import bp2_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int ENTRIES   = 16,
   parameter int RESET_CNT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_taken,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_taken
);

   localparam int       IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam bp2_cnt_t INIT_CNT = bp2_cnt_t'(RESET_CNT[1:0]);

   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("ENTRIES must be a power of two, at least 2");
      end
      if (ADDR_W < IDX_W + 2) begin : g_bad_addr
         $error("ADDR_W too narrow for the index field");
      end
      if (RESET_CNT < 0 || RESET_CNT > 3) begin : g_bad_init
         $error("RESET_CNT must lie in 0..3");
      end
   endgenerate

   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] upd_idx;

   bp2_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) rd_index_i (
      .addr (rd_addr),
      .idx  (rd_idx)
   );

   bp2_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) upd_index_i (
      .addr (upd_addr),
      .idx  (upd_idx)
   );

   bp2_cnt_t cnt_arr [ENTRIES];

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
         logic slot_hit;
         assign slot_hit = upd_valid && (upd_idx == IDX_W'(e));

         bp2_cell #(.INIT(INIT_CNT)) cell_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .hit           (slot_hit),
            .outcome_taken (upd_taken),
            .cnt_q         (cnt_arr[e])
         );
      end
   endgenerate

   // Combinational read of registered state: same-cycle update not visible.
   assign rd_taken = bp2_guess_taken(cnt_arr[rd_idx]);

endmodule

// File: rtl/bp2_counter_table_chk.sv
module bp2_counter_table_chk #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_taken,
   input logic              upd_valid,
   input logic [ADDR_W-1:0] upd_addr,
   input logic              upd_taken
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [IDX_W-1:0] c_ridx;
   logic [IDX_W-1:0] c_uidx;
   assign c_ridx = rd_addr[IDX_W+1:2];
   assign c_uidx = upd_addr[IDX_W+1:2];

   logic unused_chk;
   assign unused_chk = ^{rd_addr, upd_addr};

   // R3: a taken outcome on a slot guessing taken keeps it taken
   p_taken_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && c_uidx == c_ridx && rd_taken)
      |=> (c_ridx != $past(c_ridx)) || rd_taken);

   // R4: a not-taken outcome on a slot guessing not taken keeps it not taken
   p_not_taken_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && c_uidx == c_ridx && !rd_taken)
      |=> (c_ridx != $past(c_ridx)) || !rd_taken);

   // R6: with no valid update the read slot keeps its guess
   p_idle_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid
      |=> (c_ridx != $past(c_ridx)) || $stable(rd_taken));

   // R7: an update to another slot leaves the read slot alone
   p_other_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && c_uidx != c_ridx)
      |=> (c_ridx != $past(c_ridx)) || $stable(rd_taken));

endmodule

bind bp2_counter_table bp2_counter_table_chk #(
   .ADDR_W  (ADDR_W),
   .ENTRIES (ENTRIES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_addr   (rd_addr),
   .rd_taken  (rd_taken),
   .upd_valid (upd_valid),
   .upd_addr  (upd_addr),
   .upd_taken (upd_taken)
);

// File: tb/bp2_counter_table_tb.sv
`timescale 1ns/1ps
module bp2_counter_table_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 32;
   localparam int ENTRIES    = 16;
   localparam int NVEC       = 14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic              rd_taken;
   logic              upd_valid = 1'b0;
   logic [ADDR_W-1:0] upd_addr = '0;
   logic              upd_taken = 1'b0;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bp2_counter_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr   (rd_addr),
      .rd_taken  (rd_taken),
      .upd_valid (upd_valid),
      .upd_addr  (upd_addr),
      .upd_taken (upd_taken)
   );

   // upd valid, upd slot, upd outcome, read slot, expected guess before the edge
   typedef struct packed {
      logic       v;
      logic [3:0] us;
      logic       t;
      logic [3:0] rs;
      logic       e;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 4'd1, 1'b1, 4'd1, 1'b0},  // 2 -> 1
      '{1'b1, 4'd1, 1'b1, 4'd1, 1'b1},  // 1 -> 0
      '{1'b1, 4'd1, 1'b1, 4'd1, 1'b1},  // 0 stays 0
      '{1'b1, 4'd1, 1'b0, 4'd1, 1'b1},  // 0 -> 1
      '{1'b1, 4'd1, 1'b0, 4'd1, 1'b1},  // 1 -> 2
      '{1'b0, 4'd1, 1'b0, 4'd1, 1'b0},  // gated
      '{1'b0, 4'd1, 1'b0, 4'd1, 1'b0},  // gated
      '{1'b1, 4'd1, 1'b0, 4'd1, 1'b0},  // 2 -> 3
      '{1'b1, 4'd1, 1'b0, 4'd1, 1'b0},  // 3 stays 3
      '{1'b1, 4'd1, 1'b1, 4'd1, 1'b0},  // 3 -> 2
      '{1'b1, 4'd2, 1'b1, 4'd1, 1'b0},  // other slot: 2 -> 1
      '{1'b1, 4'd2, 1'b1, 4'd2, 1'b1},  // slot 2: 1 -> 0
      '{1'b0, 4'd0, 1'b1, 4'd1, 1'b0},  // slot 1 still 2
      '{1'b0, 4'd0, 1'b1, 4'd3, 1'b0}   // untouched slot
   };

   function automatic logic [ADDR_W-1:0] mk_addr(input logic [25:0] tag, input logic [3:0] slot);
      return {tag, slot, 2'b10};
   endfunction

   task automatic check(input logic got, input logic exp, input string req);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: rd_taken=%0b expected %0b", req, got, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [ADDR_W-1:0] ua, input logic t,
                        input logic [ADDR_W-1:0] ra);
      @(negedge clk);
      upd_valid = v;
      upd_addr  = ua;
      upd_taken = t;
      rd_addr   = ra;
      #1;
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n     = 1'b0;
      upd_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: run did not finish");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int correct;
      do_reset();

      // R1: every slot reads not taken after reset
      for (int s = 0; s < ENTRIES; s++) begin
         drive(1'b0, '0, 1'b0, mk_addr(26'h155 + 26'(s), 4'(s)));
         check(rd_taken, 1'b0, $sformatf("R1 reset slot %0d", s));
      end

      // Vector table: R2 R3 R4 R6 R7 R8
      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i].v, mk_addr(26'h3A0 + 26'(i), VEC[i].us), VEC[i].t,
               mk_addr(26'h0C5 + 26'(i * 3), VEC[i].rs));
         check(rd_taken, VEC[i].e, $sformatf("R2 R3 R4 R6 R7 vector %0d", i));
      end

      // R7: aliasing through tag bits, neighbour untouched
      drive(1'b1, mk_addr(26'h111, 4'd9), 1'b1, mk_addr(26'h222, 4'd9));
      drive(1'b1, mk_addr(26'h333, 4'd9), 1'b1, mk_addr(26'h222, 4'd9));
      drive(1'b0, '0, 1'b0, mk_addr(26'h3FF, 4'd9));
      check(rd_taken, 1'b1, "R7 alias shares slot");
      drive(1'b0, '0, 1'b0, mk_addr(26'h111, 4'd8));
      check(rd_taken, 1'b0, "R7 neighbour slot untouched");

      // R8: same-cycle read sees the old guess, next cycle the new one
      drive(1'b1, mk_addr(26'h0, 4'd12), 1'b1, mk_addr(26'h7, 4'd12));
      check(rd_taken, 1'b0, "R8 same-cycle old value");
      drive(1'b0, '0, 1'b0, mk_addr(26'h7, 4'd12));
      check(rd_taken, 1'b1, "R8 next-cycle new value");

      // R9 and R5: loop of six taken then one not taken, fresh slot 5
      correct = 0;
      for (int k = 0; k < 7; k++) begin
         drive(1'b1, mk_addr(26'h40, 4'd5), (k < 6), mk_addr(26'h41, 4'd5));
         if (rd_taken == (k < 6)) correct++;
      end
      nchk++;
      if (correct != 5) begin
         nerr++;
         $display("FAIL R9: correct guesses=%0d expected 5", correct);
      end
      drive(1'b0, '0, 1'b0, mk_addr(26'h42, 4'd5));
      check(rd_taken, 1'b1, "R9 second run first guess / R5 one miss kept");
      drive(1'b1, mk_addr(26'h40, 4'd5), 1'b0, mk_addr(26'h42, 4'd5));
      drive(1'b0, '0, 1'b0, mk_addr(26'h42, 4'd5));
      check(rd_taken, 1'b0, "R5 second miss reverses guess");

      // R1: later reset restores not taken
      do_reset();
      drive(1'b0, '0, 1'b0, mk_addr(26'h5, 4'd9));
      check(rd_taken, 1'b0, "R1 later reset slot 9");
      drive(1'b0, '0, 1'b0, mk_addr(26'h5, 4'd2));
      check(rd_taken, 1'b0, "R1 later reset slot 2");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule